// File: doc/BRIEF.md
# Double-Buffered Audio Playback Controller

This block streams 16-bit stereo samples out of a 2 KB ring buffer to a serial audio DAC. The buffer is read one 32-bit word per stereo frame: the left sample sits in the low two bytes and the right sample in the high two bytes, and each sample is stored low byte first. A host refills the buffer in two 1 KB halves, and a status bit tells it which half is playing. Every time that bit flips, the half that is not playing is free to be rewritten. The host starts, pauses and rewinds playback with single-cycle command strobes. An 8-bit volume scales each sample before it is serialised in I2S format.

The block also holds the audio status flags that pass between a console-side register interface and the host. The console raises a track request, a data request, or a control update that carries the play and repeat bits. The host serves a request and then acknowledges it with a masked set/clear write. Decoding of the console bus is not part of the block: each console event arrives as a one-cycle strobe. A data-buffer half indicator from elsewhere is passed through into the status word.

Top module: `audPlayer`

## Requirements
- R1: After reset the read pointer is 0, playback is stopped, the status flag bits are all 0, and the serial data, word-select and bit-clock outputs are all 0.
- R2: One frame lasts 64 clock cycles, split into 32 bit slots of 2 cycles each. The bit clock is 0 in the first cycle of a slot and 1 in the second. Word select is 0 for slots 0 to 15 and 1 for slots 16 to 31.
- R3: Serial data is sent MSB first with a one-slot delay. Slots 1 to 16 carry left bits 15 down to 0. Slots 17 to 31 carry right bits 15 down to 1. Slot 0 of the next frame carries right bit 0 of the previous frame.
- R4: The buffer word is split as left = bits 15:0 and right = bits 31:16, which gives a little-endian left/right pair when bytes 0 to 3 are laid out in ascending order.
- R5: Each sample sent is (sample × volume) arithmetically shifted right by 8, truncated to 16 bits. The volume is sampled in the last cycle of the frame before the one that plays it.
- R6: While running, the read pointer advances by one word in the last cycle of each frame, and it wraps from 511 to 0.
- R7: While paused, the pointer holds and frames carry all-zero samples. When play and pause arrive in the same cycle, pause wins.
- R8: A rewind strobe sets the pointer to 0 at the next clock edge. Rewind takes priority over advance.
- R9: Status bit 14 is 1 exactly while the pointer is in the upper half (word 256 or higher).
- R10: A console track request sets status bit 5 and a data request sets bit 4. A console control write sets bit 0 and loads bit 1 (play) and bit 2 (repeat) from its two inputs.
- R11: A host status write first sets the bits in its set mask and then clears the bits in its clear mask, so clear wins when both are given. A console event in the same cycle overrides the host for the bits that event writes.
- R12: Status bits 3, 6 to 12 and 15 always read 0 and cannot be set by the host. Bit 13 follows the data-half input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdPlay | input | 1 | Start or resume playback strobe |
| cmdPause | input | 1 | Pause playback strobe |
| cmdRewind | input | 1 | Set read pointer to 0 strobe |
| volume | input | 8 | Volume, gain = volume/256 |
| bufAddr | output | 9 | Word address into the audio ring buffer |
| bufData | input | 32 | Buffer word at bufAddr, same cycle |
| consoleTrackReq | input | 1 | Console asks for a new track |
| consoleDataReq | input | 1 | Console asks for a data read |
| consoleCtrlWr | input | 1 | Console wrote the play/repeat control |
| consoleCtrlPlay | input | 1 | Play value of the control write |
| consoleCtrlRepeat | input | 1 | Repeat value of the control write |
| hostStatWr | input | 1 | Host masked status write strobe |
| hostStatSet | input | 8 | Bits to set on the status low byte |
| hostStatClr | input | 8 | Bits to clear on the status low byte |
| dataHalf | input | 1 | Active data-buffer half, reflected on bit 13 |
| status | output | 16 | Status word |
| i2sBclk | output | 1 | Serial bit clock |
| i2sLrclk | output | 1 | Word select, 0 = left |
| i2sData | output | 1 | Serial sample data |

## Verification
The assertions assume that bufData is a plain combinational read of bufAddr that is valid in the same cycle, and that every command and console input is a strobe that is sampled only on clock edges. The stimulus meets these assumptions. The bench models the buffer as an array indexed directly by bufAddr, and it changes inputs only two nanoseconds after the falling edge, so the values are settled long before the next rising edge. Buffer contents are changed only while a frame load is far off, because the pointer still advances at a fixed frame rate.

// File: rtl/audPkg.sv
package audPkg;
  localparam int SAMPLE_W   = 16;
  localparam int CHANNELS   = 2;
  localparam int FRAME_BITS = SAMPLE_W * CHANNELS;
  localparam int SLOT_W     = $clog2(FRAME_BITS);
  localparam int PHASE_W    = SLOT_W + 1;
  localparam int STAT_W     = 16;
  localparam int FLAG_W     = 8;

  // status bit positions
  localparam int ST_CTRL   = 0;
  localparam int ST_PLAY   = 1;
  localparam int ST_REPEAT = 2;
  localparam int ST_DATA   = 4;
  localparam int ST_TRACK  = 5;
  localparam int ST_DHALF  = 13;
  localparam int ST_AHALF  = 14;

  localparam logic [FLAG_W-1:0] FLAG_MASK =
    FLAG_W'((1 << ST_CTRL) | (1 << ST_PLAY) | (1 << ST_REPEAT) |
            (1 << ST_DATA) | (1 << ST_TRACK));

  typedef struct packed {
    logic              frameLoad;
    logic              playing;
    logic [SLOT_W-1:0] slot;
  } audStrobe_t;
endpackage

// File: rtl/audCtrl.sv
module audCtrl
  import audPkg::*;
#(
  parameter int BUF_WORDS = 512,
  localparam int PTR_W = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdPlay,
  input  logic             cmdPause,
  input  logic             cmdRewind,
  output logic [PTR_W-1:0] ptr,
  output logic             bitClk,
  output logic             wordSel,
  output audStrobe_t       strobe
);
  logic [PHASE_W-1:0] phase;
  logic               running;
  logic               lastCycle;

  assign lastCycle = (phase == {PHASE_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         running <= 1'b0;
    else if (cmdPause) running <= 1'b0;
    else if (cmdPlay)  running <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     ptr <= '0;
    else if (cmdRewind)            ptr <= '0;
    else if (lastCycle && running) ptr <= ptr + 1'b1;
  end

  assign bitClk           = phase[0];
  assign wordSel          = phase[PHASE_W-1];
  assign strobe.frameLoad = lastCycle;
  assign strobe.playing   = running;
  assign strobe.slot      = phase[PHASE_W-1:1];

  p_rewind_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdRewind |=> ptr == '0);
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cmdRewind) |=> $stable(ptr));
  p_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && running && !cmdRewind) |=> ptr == PTR_W'($past(ptr) + 1'b1));
  p_mid_frame_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!lastCycle && !cmdRewind) |=> $stable(ptr));
  p_pause_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdPause |=> !running);
endmodule

// File: rtl/audStatus.sv
module audStatus
  import audPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trackReq,
  input  logic              dataReq,
  input  logic              ctrlWr,
  input  logic              ctrlPlay,
  input  logic              ctrlRepeat,
  input  logic              hostWr,
  input  logic [FLAG_W-1:0] hostSet,
  input  logic [FLAG_W-1:0] hostClr,
  input  logic              audioHalf,
  input  logic              dataHalf,
  output logic [STAT_W-1:0] status
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    flagsNext = flags;
    if (hostWr) flagsNext = (flagsNext | hostSet) & ~hostClr;
    if (trackReq) flagsNext[ST_TRACK] = 1'b1;
    if (dataReq)  flagsNext[ST_DATA]  = 1'b1;
    if (ctrlWr) begin
      flagsNext[ST_CTRL]   = 1'b1;
      flagsNext[ST_PLAY]   = ctrlPlay;
      flagsNext[ST_REPEAT] = ctrlRepeat;
    end
    flagsNext = flagsNext & FLAG_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  always_comb begin
    status           = '0;
    status[FLAG_W-1:0] = flags;
    status[ST_DHALF] = dataHalf;
    status[ST_AHALF] = audioHalf;
  end

  p_track_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    trackReq |=> flags[ST_TRACK]);
  p_data_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |=> flags[ST_DATA]);
  p_ctrl_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (flags[ST_CTRL] && flags[ST_PLAY] == $past(ctrlPlay)
                && flags[ST_REPEAT] == $past(ctrlRepeat)));
  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostClr[ST_DATA] && !dataReq) |=> !flags[ST_DATA]);
  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~FLAG_MASK) == '0);
endmodule

// File: rtl/audDatapath.sv
module audDatapath
  import audPkg::*;
#(
  parameter int VOL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  audStrobe_t            strobe,
  input  logic [FRAME_BITS-1:0] bufData,
  input  logic [VOL_W-1:0]      volume,
  output logic                  serialOut
);
  localparam int PROD_W = SAMPLE_W + VOL_W + 1;

  logic [FRAME_BITS-1:0] loadWord;
  logic [FRAME_BITS-1:0] curWord;
  logic [FRAME_BITS-1:0] prevWord;
  logic [SLOT_W-1:0]     bitIdx;

  // ch 0 = left (buffer low half), sent first, so placed in the upper half
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic signed [SAMPLE_W-1:0] sample;
    logic signed [PROD_W-1:0]   prod;
    assign sample = bufData[ch*SAMPLE_W +: SAMPLE_W];
    assign prod   = PROD_W'(sample) * PROD_W'($signed({1'b0, volume}));
    assign loadWord[(CHANNELS-1-ch)*SAMPLE_W +: SAMPLE_W] = prod[VOL_W +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord  <= '0;
      prevWord <= '0;
    end else if (strobe.frameLoad) begin
      prevWord <= curWord;
      curWord  <= strobe.playing ? loadWord : '0;
    end
  end

  // slot s (1..31) carries bit FRAME_BITS-s; slot 0 carries the last bit of the previous frame
  assign bitIdx    = SLOT_W'(0) - strobe.slot;
  assign serialOut = (strobe.slot == '0) ? prevWord[0] : curWord[bitIdx];

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameLoad && !strobe.playing) |=> curWord == '0);
  p_prev_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameLoad |=> prevWord == $past(curWord));
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameLoad |=> $stable(curWord));
endmodule

// File: rtl/audPlayer.sv
module audPlayer
  import audPkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int VOL_W = 8,
  localparam int PTR_W = $clog2(BUF_WORDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdPlay,
  input  logic                  cmdPause,
  input  logic                  cmdRewind,
  input  logic [VOL_W-1:0]      volume,
  output logic [PTR_W-1:0]      bufAddr,
  input  logic [FRAME_BITS-1:0] bufData,
  input  logic                  consoleTrackReq,
  input  logic                  consoleDataReq,
  input  logic                  consoleCtrlWr,
  input  logic                  consoleCtrlPlay,
  input  logic                  consoleCtrlRepeat,
  input  logic                  hostStatWr,
  input  logic [FLAG_W-1:0]     hostStatSet,
  input  logic [FLAG_W-1:0]     hostStatClr,
  input  logic                  dataHalf,
  output logic [STAT_W-1:0]     status,
  output logic                  i2sBclk,
  output logic                  i2sLrclk,
  output logic                  i2sData
);
  audStrobe_t strobe;

  audCtrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdPlay(cmdPlay), .cmdPause(cmdPause), .cmdRewind(cmdRewind),
    .ptr(bufAddr), .bitClk(i2sBclk), .wordSel(i2sLrclk), .strobe(strobe)
  );

  audDatapath #(.VOL_W(VOL_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bufData(bufData), .volume(volume), .serialOut(i2sData)
  );

  audStatus u_stat (
    .clk(clk), .rstN(rstN),
    .trackReq(consoleTrackReq), .dataReq(consoleDataReq),
    .ctrlWr(consoleCtrlWr), .ctrlPlay(consoleCtrlPlay), .ctrlRepeat(consoleCtrlRepeat),
    .hostWr(hostStatWr), .hostSet(hostStatSet), .hostClr(hostStatClr),
    .audioHalf(bufAddr[PTR_W-1]), .dataHalf(dataHalf), .status(status)
  );

  p_half_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    status[ST_AHALF] == (bufAddr >= PTR_W'(BUF_WORDS / 2)));
endmodule

// File: tb/sim_audPlayer.sv
module sim_audPlayer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdPlay = 0, cmdPause = 0, cmdRewind = 0;
  logic [7:0] volume = 0;
  logic [8:0] bufAddr;
  logic [31:0] bufData;
  logic trackReq = 0, dataReq = 0, ctrlWr = 0, ctrlPlay = 0, ctrlRepeat = 0;
  logic hostWr = 0;
  logic [7:0] hostSet = 0, hostClr = 0;
  logic dataHalf = 0;
  logic [15:0] status;
  logic bclk, lrclk, sdata;

  logic [31:0] mem [512];
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  assign bufData = mem[bufAddr];

  audPlayer u0 (
    .clk(clk), .rstN(rstN), .cmdPlay(cmdPlay), .cmdPause(cmdPause), .cmdRewind(cmdRewind),
    .volume(volume), .bufAddr(bufAddr), .bufData(bufData),
    .consoleTrackReq(trackReq), .consoleDataReq(dataReq), .consoleCtrlWr(ctrlWr),
    .consoleCtrlPlay(ctrlPlay), .consoleCtrlRepeat(ctrlRepeat),
    .hostStatWr(hostWr), .hostStatSet(hostSet), .hostStatClr(hostClr),
    .dataHalf(dataHalf), .status(status),
    .i2sBclk(bclk), .i2sLrclk(lrclk), .i2sData(sdata)
  );

  // ---------------- behavioural reference model ----------------
  int mPhase, mPtr;
  bit mRun;
  logic [31:0] mCur, mPrev;
  logic [5:0] mFlags;

  function automatic logic [15:0] scl(logic [15:0] s, logic [7:0] v);
    int p;
    p = int'($signed(s)) * int'(v);
    return 16'(p >>> 8);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mPtr = 0; mRun = 0; mCur = 0; mPrev = 0; mFlags = 0;
    end else begin
      logic [5:0] f;
      if (mPhase == 63) begin
        mPrev = mCur;
        mCur = mRun ? {scl(mem[mPtr][15:0], volume), scl(mem[mPtr][31:16], volume)} : 32'h0;
      end
      if (cmdRewind) mPtr = 0;
      else if (mPhase == 63 && mRun) mPtr = (mPtr + 1) % 512;
      if (cmdPause) mRun = 0; else if (cmdPlay) mRun = 1;
      mPhase = (mPhase + 1) % 64;
      f = mFlags;
      if (hostWr) f = (f | hostSet[5:0]) & ~hostClr[5:0];
      if (trackReq) f[5] = 1;
      if (dataReq) f[4] = 1;
      if (ctrlWr) begin f[0] = 1; f[1] = ctrlPlay; f[2] = ctrlRepeat; end
      f[3] = 0;
      mFlags = f;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) if (rstN) begin
    int slot;
    logic eData;
    logic [15:0] eStat;
    bit bad;
    slot = mPhase / 2;
    eData = (slot == 0) ? mPrev[0] : mCur[32 - slot];
    eStat = {1'b0, (mPtr >= 256), dataHalf, 7'b0, mFlags};
    bad = 0;
    checks++;
    if (bclk !== 1'(mPhase % 2) || lrclk !== (slot >= 16)) begin
      bad = 1; $display("FAIL R2 clocks act=%b%b exp=%b%b", bclk, lrclk, 1'(mPhase % 2), slot >= 16);
    end
    if (sdata !== eData) begin
      bad = 1; $display("FAIL R3 data slot %0d act=%b exp=%b", slot, sdata, eData);
    end
    if (bufAddr !== 9'(mPtr)) begin
      bad = 1; $display("FAIL R6 pointer act=%0d exp=%0d", bufAddr, mPtr);
    end
    if (status !== eStat) begin
      bad = 1; $display("FAIL R10 R11 status act=%h exp=%h", status, eStat);
    end
    if (bad) fails++;
  end

  // ---------------- directed checks ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic grab(output logic [31:0] w);
    logic prevLr = 1'b0;
    forever begin
      @(negedge clk);
      if (prevLr && !lrclk) break;
      prevLr = lrclk;
    end
    for (int s = 1; s <= 32; s++) begin
      repeat (2) @(negedge clk);
      w[32 - s] = sdata;
    end
    #2;
  endtask

  task automatic waitAddr(int a);
    for (int i = 0; i < 40000 && bufAddr != 9'(a); i++) tick();
    for (int i = 0; i < 200 && bufAddr == 9'(a); i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [8:0] held;
    for (int i = 0; i < 512; i++) mem[i] = 32'hFF00_1234;
    tick(4);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 pointer", 32'(bufAddr), 32'h0);
    chk("R1 outputs", {29'h0, sdata, lrclk, bclk}, 32'h0);

    // R4 R5 sample decode and scaling
    volume = 8'd128;
    cmdPlay = 1; tick(); cmdPlay = 0;
    grab(w); grab(w);
    chk("R4 R5 vol128", w, 32'h091A_FF80);
    volume = 8'd255;
    grab(w); grab(w);
    chk("R5 vol255", w, 32'h1221_FF01);
    volume = 8'd0;
    grab(w); grab(w);
    chk("R5 vol0", w, 32'h0);
    volume = 8'd200;

    // R7 pause
    cmdPause = 1; tick(); cmdPause = 0;
    grab(w); grab(w);
    chk("R7 silent", w, 32'h0);
    held = bufAddr;
    tick(300);
    chk("R7 hold", 32'(bufAddr), 32'(held));
    cmdPause = 1; cmdPlay = 1; tick(); cmdPause = 0; cmdPlay = 0;
    grab(w); grab(w);
    chk("R7 pause wins", w, 32'h0);

    // varied content for the long run
    for (int i = 0; i < 512; i++) mem[i] = {16'(i * 97 - 3000), 16'(i * 131 + 7)};
    cmdPlay = 1; tick(); cmdPlay = 0;
    tick(64 * 10);
    chk("R6 advanced", 32'(bufAddr != 0), 32'h1);
    cmdRewind = 1; tick(); cmdRewind = 0;
    chk("R8 rewind", 32'(bufAddr), 32'h0);

    // R6 R9 half crossing and wrap
    waitAddr(255);
    chk("R6 step to 256", 32'(bufAddr), 32'd256);
    chk("R9 upper half", 32'(status[14]), 32'h1);
    waitAddr(511);
    chk("R6 wrap", 32'(bufAddr), 32'h0);
    chk("R9 lower half", 32'(status[14]), 32'h0);

    // R10 R11 R12 status flags
    trackReq = 1; tick(); trackReq = 0;
    chk("R10 track", 32'(status[5:0]), 32'h20);
    dataReq = 1; tick(); dataReq = 0;
    ctrlWr = 1; ctrlPlay = 1; ctrlRepeat = 0; tick(); ctrlWr = 0;
    chk("R10 ctrl", 32'(status[5:0]), 32'h33);
    hostWr = 1; hostSet = 8'hCC; hostClr = 8'h01; tick(); hostWr = 0;
    chk("R12 reserved", 32'(status[7:0]), 32'h36);
    hostWr = 1; hostSet = 8'h10; hostClr = 8'h10; tick(); hostWr = 0;
    chk("R11 clear wins", 32'(status[7:0]), 32'h26);
    hostWr = 1; hostSet = 8'h00; hostClr = 8'h20; trackReq = 1; tick();
    hostWr = 0; trackReq = 0;
    chk("R11 console wins", 32'(status[7:0]), 32'h26);
    dataHalf = 1; #1;
    chk("R12 data half", 32'(status[15:13]), 32'h1);
    tick(64);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule